// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation miss by searching an inverted, hashed page table held in memory. It runs only after a miss that no block-mapping register has covered. The top four bits of a 32-bit effective address pick one of sixteen segment registers. The 24-bit segment identifier held there takes the place of those four bits, which gives a 52-bit virtual address. From that address the walker computes a group index. It then reads the eight page table entries of that group, one at a time, over a plain request/acknowledge memory port.

If no entry in the first group matches, the walker repeats the search in a second group, chosen by a second hash. If that search fails too, it reports a trap together with the faulting address. Each segment register also holds a no-execute flag. An instruction fetch into a flagged segment traps at once and reads no memory. On a hit the walker returns the physical frame number of the entry. Software fills the segment registers through a write port and sets the table size through a group mask input.

Top module: `hpt_walker`

## Requirements
- R1: Segment selection and address forming. Effective address bits [31:28] select a segment register. The virtual page is bits [27:12]. The abbreviated page index is bits [27:22]. An entry matches only if its 24-bit identifier equals the identifier in the selected segment register.
- R2: Primary group. The primary hash is the low 19 bits of the segment identifier XOR the zero-extended 16-bit page number, ANDed with `tbl_mask_i`. The entry address is {group, slot}: the group in bits [21:3] and the slot in bits [2:0], counted in entries.
- R3: Order of reads. Within a group the walker reads slots 0 to 7 in ascending order. It stops at the first matching entry, so a hit in slot s of the first pass takes exactly s+1 reads.
- R4: Entry format and match rule. The 52-bit entry holds valid in bit 0, the hash-select bit in bit 1, the abbreviated page index in bits [7:2], the segment identifier in bits [31:8] and the frame in bits [51:32]. An entry matches when valid is 1, the identifier and the abbreviated index are equal, and hash-select equals the pass number (0 for primary, 1 for secondary).
- R5: Secondary pass. When no slot of the primary group matches, the walker searches the group given by the one's complement of the primary hash, ANDed with the mask, and reads it in slot order. A hit in slot s of this pass takes 8+s+1 reads in total.
- R6: Trap after both passes. When neither pass matches, the walker completes with `trap_o`=1 and `hit_o`=0 after exactly 16 reads. `fault_ea_o` then holds the request address.
- R7: No-execute. An instruction fetch (`req_fetch_i`=1) into a segment whose no-execute flag is set completes with `trap_o`=1 and `nx_fault_o`=1. It makes no memory read, and `done_o` rises one cycle after the request is accepted. A data access to the same segment is unaffected.
- R8: Memory port. `mem_req_o` stays high, and `mem_addr_o` stays stable, until `mem_ack_i` is sampled high. Each acknowledged beat delivers one entry.
- R9: One request at a time. `ready_o` is high only when the walker is idle and not signalling completion, and `req_valid_i` is ignored at all other times. Each accepted request produces exactly one single-cycle `done_o` pulse, with exactly one of `hit_o` and `trap_o` set.
- R10: Reset. While `rst_ni` is low, `ready_o`=1, `done_o`=0 and `mem_req_o`=0. All segment registers are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_we_i | input | 1 | Segment register write enable |
| seg_idx_i | input | 4 | Segment register to write |
| seg_sid_i | input | 24 | Segment identifier to write |
| seg_nx_i | input | 1 | No-execute flag to write |
| tbl_mask_i | input | 19 | Group index mask (table size) |
| req_valid_i | input | 1 | Walk request |
| req_ea_i | input | 32 | Effective address of the miss |
| req_fetch_i | input | 1 | Request is an instruction fetch |
| ready_o | output | 1 | Walker can accept a request |
| mem_req_o | output | 1 | Entry read request |
| mem_addr_o | output | 22 | Entry address {group, slot} |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | 52 | Entry read data |
| done_o | output | 1 | Walk finished (one-cycle pulse) |
| hit_o | output | 1 | Walk found a matching entry |
| trap_o | output | 1 | Walk failed, software must handle it |
| nx_fault_o | output | 1 | Trap caused by the no-execute flag |
| frame_o | output | 20 | Physical frame on a hit |
| fault_ea_o | output | 32 | Address of the request that trapped |

## Verification
Two things can fall in the same cycle. One is the acknowledge that ends the last primary slot or the final secondary slot. The other is a fresh request held on `req_valid_i` while the walk is still running. The bench provokes this by keeping a second, different address asserted for the whole walk, and by giving the memory acknowledge a random latency. It then checks three things: the single completion carries the result computed for the first address, no second `done_o` follows, and the read count matches the slot-order model.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int EA_W    = 32;
  localparam int SEG_N   = 16;
  localparam int IDX_W   = $clog2(SEG_N);
  localparam int SID_W   = 24;
  localparam int OFF_W   = 12;
  localparam int PAGE_W  = EA_W - IDX_W - OFF_W;
  localparam int API_W   = 6;
  localparam int HASH_W  = 19;
  localparam int SLOTS   = 8;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int FRAME_W = 20;
  localparam int ADDR_W  = HASH_W + SLOT_W;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic [SID_W-1:0]   sid;
    logic [API_W-1:0]   api;
    logic               hsel;
    logic               valid;
  } pte_t;

  localparam int PTE_W = $bits(pte_t);
endpackage

// File: rtl/hpt_seg_file.sv
module hpt_seg_file #(
  parameter int N = 16,
  parameter int W = 24,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wsid_i,
  input  logic          wnx_i,
  input  logic [IW-1:0] ridx_i,
  output logic [W-1:0]  rsid_o,
  output logic          rnx_o
);
  logic [W-1:0] sid_q [N];
  logic [N-1:0] nx_q;

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sid_q[g] <= '0;
        nx_q[g]  <= 1'b0;
      end else if (we_i && widx_i == IW'(g)) begin
        sid_q[g] <= wsid_i;
        nx_q[g]  <= wnx_i;
      end
    end
  end

  assign rsid_o = sid_q[ridx_i];
  assign rnx_o  = nx_q[ridx_i];
endmodule

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
(
  input  logic [SID_W-1:0]  sid_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [HASH_W-1:0] mask_i,
  input  logic              sec_i,
  output logic [HASH_W-1:0] grp_o
);
  logic [HASH_W-1:0] prim;
  assign prim  = sid_i[HASH_W-1:0] ^ HASH_W'(page_i);
  assign grp_o = (sec_i ? ~prim : prim) & mask_i;
endmodule

// File: rtl/hpt_match.sv
module hpt_match
  import hpt_pkg::*;
(
  input  pte_t             pte_i,
  input  logic [SID_W-1:0] sid_i,
  input  logic [API_W-1:0] api_i,
  input  logic             pass_i,
  output logic             hit_o
);
  assign hit_o = pte_i.valid && (pte_i.sid == sid_i) &&
                 (pte_i.api == api_i) && (pte_i.hsel == pass_i);
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                seg_we_i,
  input  logic [IDX_W-1:0]    seg_idx_i,
  input  logic [SID_W-1:0]    seg_sid_i,
  input  logic                seg_nx_i,
  input  logic [HASH_W-1:0]   tbl_mask_i,
  input  logic                req_valid_i,
  input  logic [EA_W-1:0]     req_ea_i,
  input  logic                req_fetch_i,
  output logic                ready_o,
  output logic                mem_req_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                mem_ack_i,
  input  logic [PTE_W-1:0]    mem_rdata_i,
  output logic                done_o,
  output logic                hit_o,
  output logic                trap_o,
  output logic                nx_fault_o,
  output logic [FRAME_W-1:0]  frame_o,
  output logic [EA_W-1:0]     fault_ea_o
);
  localparam int IDX_LO = EA_W - IDX_W;
  localparam int API_LO = IDX_LO - API_W;

  typedef enum logic {S_IDLE, S_READ} st_e;

  st_e               st_q;
  logic [EA_W-1:0]   ea_q;
  logic [SID_W-1:0]  sid_q;
  logic              pass_q;
  logic [SLOT_W-1:0] slot_q;
  logic              done_q, hit_q, trap_q, nx_q;
  logic [FRAME_W-1:0] frame_q;

  logic [SID_W-1:0]  lk_sid;
  logic              lk_nx;
  logic [HASH_W-1:0] grp;
  logic              m_hit;
  pte_t              pte;
  logic              accept, last_slot;

  hpt_seg_file #(.N(SEG_N), .W(SID_W)) u_seg (
    .clk_i, .rst_ni,
    .we_i(seg_we_i), .widx_i(seg_idx_i), .wsid_i(seg_sid_i), .wnx_i(seg_nx_i),
    .ridx_i(req_ea_i[EA_W-1 -: IDX_W]), .rsid_o(lk_sid), .rnx_o(lk_nx)
  );

  hpt_hash u_hash (
    .sid_i(sid_q), .page_i(ea_q[IDX_LO-1:OFF_W]), .mask_i(tbl_mask_i),
    .sec_i(pass_q), .grp_o(grp)
  );

  assign pte = pte_t'(mem_rdata_i);

  hpt_match u_match (
    .pte_i(pte), .sid_i(sid_q), .api_i(ea_q[IDX_LO-1:API_LO]),
    .pass_i(pass_q), .hit_o(m_hit)
  );

  assign ready_o    = (st_q == S_IDLE) && !done_q;
  assign accept     = req_valid_i && ready_o;
  assign mem_req_o  = (st_q == S_READ);
  assign mem_addr_o = {grp, slot_q};
  assign last_slot  = (slot_q == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      ea_q    <= '0;
      sid_q   <= '0;
      pass_q  <= 1'b0;
      slot_q  <= '0;
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      trap_q  <= 1'b0;
      nx_q    <= 1'b0;
      frame_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        ea_q   <= req_ea_i;
        sid_q  <= lk_sid;
        pass_q <= 1'b0;
        slot_q <= '0;
        if (req_fetch_i && lk_nx) begin
          done_q <= 1'b1;
          hit_q  <= 1'b0;
          trap_q <= 1'b1;
          nx_q   <= 1'b1;
        end else begin
          st_q <= S_READ;
        end
      end else if (st_q == S_READ && mem_ack_i) begin
        if (m_hit) begin
          st_q    <= S_IDLE;
          done_q  <= 1'b1;
          hit_q   <= 1'b1;
          trap_q  <= 1'b0;
          nx_q    <= 1'b0;
          frame_q <= pte.frame;
        end else if (!last_slot) begin
          slot_q <= slot_q + 1'b1;
        end else if (!pass_q) begin
          pass_q <= 1'b1;
          slot_q <= '0;
        end else begin
          st_q   <= S_IDLE;
          done_q <= 1'b1;
          hit_q  <= 1'b0;
          trap_q <= 1'b1;
          nx_q   <= 1'b0;
        end
      end
    end
  end

  assign done_o     = done_q;
  assign hit_o      = hit_q;
  assign trap_o     = trap_q;
  assign nx_fault_o = nx_q;
  assign frame_o    = frame_q;
  assign fault_ea_o = ea_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (hit_o != trap_o)); // R9
  AST_EA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> $stable(fault_ea_o)); // R9
  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o); // R9
  AST_NX_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && req_fetch_i && lk_nx |=> done_o && trap_o && nx_fault_o && !mem_req_o); // R7
  AST_MASKED_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && $stable(tbl_mask_i) |-> (mem_addr_o[ADDR_W-1:SLOT_W] & ~tbl_mask_i) == '0); // R2
endmodule

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
  import hpt_pkg::*;

  localparam logic [HASH_W-1:0] MASK = 19'h003FF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic seg_we = 0, seg_nx = 0, req_valid = 0, req_fetch = 0;
  logic [3:0] seg_idx = '0;
  logic [23:0] seg_sid = '0;
  logic [HASH_W-1:0] tbl_mask = MASK;
  logic [31:0] req_ea = '0;
  logic ready, mem_req, mem_ack = 0, done, hit, trap, nxf;
  logic [ADDR_W-1:0] mem_addr;
  logic [PTE_W-1:0] mem_rdata = '0;
  logic [FRAME_W-1:0] frame;
  logic [31:0] fault_ea;

  hpt_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .seg_we_i(seg_we), .seg_idx_i(seg_idx),
    .seg_sid_i(seg_sid), .seg_nx_i(seg_nx), .tbl_mask_i(tbl_mask),
    .req_valid_i(req_valid), .req_ea_i(req_ea), .req_fetch_i(req_fetch),
    .ready_o(ready), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .done_o(done), .hit_o(hit),
    .trap_o(trap), .nx_fault_o(nxf), .frame_o(frame), .fault_ea_o(fault_ea)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0, nreads = 0, hold_viol = 0;
  logic [PTE_W-1:0] mem [int unsigned];
  logic [23:0] m_sid [16];
  logic        m_nx  [16];

  task automatic chk(bit ok, string rq, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [PTE_W-1:0] rd(logic [ADDR_W-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : '0;
  endfunction

  function automatic logic [PTE_W-1:0] mk(logic [19:0] f, logic [23:0] s,
                                           logic [5:0] api, bit h, bit v);
    return {f, s, api, h, v};
  endfunction

  function automatic logic [HASH_W-1:0] grp_of(logic [23:0] s, logic [15:0] pg, bit sec);
    logic [HASH_W-1:0] h;
    h = s[HASH_W-1:0] ^ {3'b000, pg};
    if (sec) h = ~h;
    return h & MASK;
  endfunction

  function automatic int unsigned eaddr(logic [HASH_W-1:0] g, int slot);
    return {g, 3'(slot)};
  endfunction

  // reference model from the requirements
  task automatic model(input logic [31:0] ea, input bit fetch, output bit e_hit,
                       output bit e_nx, output logic [19:0] e_frame, output int e_reads);
    logic [23:0] s;
    logic [PTE_W-1:0] p;
    s = m_sid[ea[31:28]];
    e_hit = 0; e_nx = 0; e_frame = '0; e_reads = 0;
    if (fetch && m_nx[ea[31:28]]) begin e_nx = 1; return; end
    for (int ps = 0; ps < 2; ps++) begin
      for (int sl = 0; sl < 8; sl++) begin
        p = rd(ADDR_W'(eaddr(grp_of(s, ea[27:12], ps[0]), sl)));
        e_reads++;
        if (p[0] && p[31:8] == s && p[7:2] == ea[27:22] && p[1] == ps[0]) begin
          e_hit = 1; e_frame = p[51:32]; return;
        end
      end
    end
  endtask

  // memory responder with random latency and handshake monitor (R8)
  logic p_req = 0, p_ack = 0;
  logic [ADDR_W-1:0] p_addr = '0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n && p_req && !p_ack && !(mem_req && mem_addr == p_addr)) hold_viol++;
    if (mem_req && ($urandom % 3 != 0)) begin
      mem_ack = 1; mem_rdata = rd(mem_addr); nreads++;
    end else mem_ack = 0;
    p_req = mem_req; p_ack = mem_ack; p_addr = mem_addr;
  end

  task automatic wr_seg(int i, logic [23:0] s, bit nx);
    @(negedge clk);
    seg_we = 1; seg_idx = 4'(i); seg_sid = s; seg_nx = nx;
    m_sid[i] = s; m_nx[i] = nx;
    @(negedge clk);
    seg_we = 0;
  endtask

  task automatic run(logic [31:0] ea, bit fetch, string tag, bit busy_poke = 0);
    bit e_hit, e_nx, got;
    logic [19:0] e_fr;
    int e_rd, extra, waitc;
    model(ea, fetch, e_hit, e_nx, e_fr, e_rd);
    @(negedge clk);
    while (!ready) @(negedge clk);
    nreads = 0;
    req_valid = 1; req_ea = ea; req_fetch = fetch;
    @(negedge clk);
    if (busy_poke) begin req_ea = ~ea; req_fetch = 0; end
    else req_valid = 0;
    got = 0; waitc = 0;
    while (!got && waitc < 300) begin
      if (done) got = 1; else begin @(negedge clk); waitc++; end
    end
    req_valid = 0;
    chk(got, {tag, " R9 done"}, got, 1);
    chk(hit == e_hit && trap == !e_hit, {tag, " R4 hit/trap"}, {hit, trap}, {e_hit, !e_hit});
    chk(nxf == e_nx, {tag, " R7 nx"}, nxf, e_nx);
    if (e_hit) chk(frame == e_fr, {tag, " R3 frame"}, frame, e_fr);
    else chk(fault_ea == ea, {tag, " R6 fault_ea"}, fault_ea, ea);
    chk(nreads == e_rd, {tag, " R3 reads"}, nreads, e_rd);
    extra = 0;
    repeat (4) begin @(negedge clk); if (done) extra++; end
    chk(extra == 0, {tag, " R9 single done"}, extra, 0);
  endtask

  initial begin
    int n;
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", cycles, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] ea;
    logic [23:0] s;
    logic [HASH_W-1:0] g0, g1;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin m_sid[i] = '0; m_nx[i] = 0; end
    repeat (3) @(negedge clk);
    chk(ready == 1 && done == 0 && mem_req == 0, "R10 reset", {ready, done, mem_req}, 3'b100);
    rst_n = 1;
    for (int i = 0; i < 16; i++) wr_seg(i, 24'($urandom), (i == 5));

    // R1/R2/R3: primary hit in slot 0 and slot 7
    ea = 32'h3ABC_D123; s = m_sid[3];
    g0 = grp_of(s, ea[27:12], 0);
    mem[eaddr(g0, 0)] = mk(20'hA1A1A, s, ea[27:22], 0, 1);
    run(ea, 0, "R2 prim slot0");
    mem.delete();
    mem[eaddr(g0, 7)] = mk(20'h77777, s, ea[27:22], 0, 1);
    mem[eaddr(g0, 2)] = mk(20'h11111, s, ea[27:22], 0, 0);          // invalid
    mem[eaddr(g0, 3)] = mk(20'h22222, s ^ 24'h1, ea[27:22], 0, 1);  // wrong sid
    mem[eaddr(g0, 4)] = mk(20'h33333, s, ea[27:22] ^ 6'h1, 0, 1);   // wrong api
    mem[eaddr(g0, 5)] = mk(20'h44444, s, ea[27:22], 1, 1);          // wrong hash select
    run(ea, 0, "R4 prim slot7 decoys");
    // R1: same page through another segment must miss
    run({4'h4, ea[27:0]}, 0, "R1 other segment");
    // R5: secondary hit only
    mem.delete();
    g1 = grp_of(s, ea[27:12], 1);
    mem[eaddr(g1, 3)] = mk(20'h5EC03, s, ea[27:22], 1, 1);
    mem[eaddr(g0, 1)] = mk(20'hBAD01, s, ea[27:22], 1, 1);
    run(ea, 0, "R5 secondary slot3");
    // R3: primary wins over secondary
    mem[eaddr(g0, 6)] = mk(20'hF0F06, s, ea[27:22], 0, 1);
    run(ea, 0, "R3 primary first");
    // R6: empty table traps after 16 reads
    mem.delete();
    run(ea, 0, "R6 both miss");
    // R7: fetch to nx segment, then data access to it
    ea = 32'h5123_4000; s = m_sid[5];
    mem[eaddr(grp_of(s, ea[27:12], 0), 2)] = mk(20'h0CAFE, s, ea[27:22], 0, 1);
    run(ea, 1, "R7 nx fetch");
    run(ea, 0, "R7 nx data ok");
    run({4'h6, ea[27:0]}, 1, "R7 fetch other seg");
    // R9: request held during the walk is ignored
    run(ea, 0, "R9 busy ignore", 1);
    mem.delete();

    // constrained random
    for (int t = 0; t < 80; t++) begin
      int mode, sl;
      ea = $urandom;
      s = m_sid[ea[31:28]];
      g0 = grp_of(s, ea[27:12], 0);
      g1 = grp_of(s, ea[27:12], 1);
      mode = $urandom % 4;
      sl = $urandom % 8;
      for (int d = 0; d < 8; d++)
        if ($urandom % 2 == 1)
          mem[eaddr((d % 2 == 1) ? g1 : g0, d)] =
            mk(20'($urandom), s ^ 24'($urandom % 2), ea[27:22] ^ 6'($urandom % 2),
               1'($urandom), 1'($urandom));
      if (mode == 1) mem[eaddr(g0, sl)] = mk(20'($urandom), s, ea[27:22], 0, 1);
      if (mode == 2) mem[eaddr(g1, sl)] = mk(20'($urandom), s, ea[27:22], 1, 1);
      run(ea, ($urandom % 4 == 0), "R3 random", ($urandom % 3 == 0));
      mem.delete();
    end

    chk(hold_viol == 0, "R8 request hold", hold_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule